// File: doc/BRIEF.md
# ADC Sample Gain Calibration Stage

This block sits in a streaming sample path behind an analog-to-digital converter. Each incoming word is a 16-bit two's complement value. The converter's 14-bit code occupies the upper fourteen bits of that word, and the bottom two bits arrive as zero. The stage multiplies each sample by a programmable unsigned gain, where 1024 means unity. It rounds the scaled value to the nearest 16-bit code and adds a signed offset. The two bottom bits of the result therefore carry the fraction produced by the gain instead of being thrown away.

If an arithmetic step leaves the 16-bit signed range, that step clamps its value to the nearest limit and the event sets a sticky overflow flag. The flag stays set until software pulses a clear input. Gain and offset are loaded through write strobes. Each accepted sample carries the parameter values that were in force when it was accepted, so a result never mixes old and new settings.

Top module: `adc_gain_cal`

## Requirements
- R1: While reset is high and on the first clock after it is released, `out_valid`, `out_data` and `ovf_flag` are all zero. The gain resets to 1024 and the offset resets to 0.
- R2: The scaled value is (sample × gain + 512) >> 10, using an arithmetic shift, which rounds to the nearest code with ties toward positive. With gain 1063 and offset 0, inputs 0x0000, 0x0004, 0x0008 and 0x000B return unchanged. With the same settings, 0x0010, 0x0014, 0x0018 and 0x001B become 0x0011, 0x0015, 0x0019 and 0x001C.
- R3: The gain is a 16-bit unsigned number in units of 1/1024. With gain 1024 and offset 0, every input code, including 0x8000 and 0x7FFC, comes out unchanged and does not set the overflow flag.
- R4: A scaled value above 32767 becomes 0x7FFF, and one below -32768 becomes 0x8000. Either case sets the overflow flag.
- R5: The signed 16-bit offset is added after rounding. If the sum leaves the 16-bit range it clamps to 0x7FFF or 0x8000 and sets the overflow flag. An overflow in the scaling step sets the flag even when the offset brings the final value back inside the range.
- R6: A sample presented with `in_valid` high at a rising edge appears on `out_data`, with `out_valid` high, after the next rising edge. This is two register stages. `out_valid` is high only for such samples.
- R7: While `out_valid` is low, `out_data` keeps the last result.
- R8: `ovf_flag` stays set until `ovf_clr` is high at a rising edge. If a new overflow result is registered at the same edge, the flag stays set.
- R9: A gain or offset write applies to samples accepted at later edges. A sample accepted at the same edge as the write is computed with the earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Two's complement sample, converter code in bits 15:2 |
| gain_we | input | 1 | Write strobe for the gain |
| gain_wdata | input | 16 | Unsigned gain, 1024 = unity |
| offset_we | input | 1 | Write strobe for the offset |
| offset_wdata | input | 16 | Signed offset added after scaling |
| ovf_clr | input | 1 | One-cycle clear of the overflow flag |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | 16 | Calibrated two's complement result |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
A sample driven at a falling edge is captured at the next rising edge. Its result, its `out_valid` and the overflow flag bit it causes are all registered at the rising edge after that. The bench therefore compares each sample's expected result with the outputs two falling edges later, using a two-entry delay line of expectations. A clear input driven at a falling edge acts at the following rising edge, so the expected flag is built from the clear driven one falling edge earlier and the overflow expected from the result due now. Parameter writes update the bench's model only after the same-cycle sample has been modelled, which matches the write-timing rule.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  // Shared dimensions of the calibration datapath
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned GAIN_W   = 16;
  localparam int unsigned FRAC_SH  = 10;

  // Reason a result was clamped (diagnostic encoding only)
  typedef enum logic [1:0] {
    CLAMP_NONE  = 2'd0,
    CLAMP_SCALE = 2'd1,
    CLAMP_SUM   = 2'd2,
    CLAMP_BOTH  = 2'd3
  } clamp_kind_e;
endpackage

// File: rtl/cal_param_bank.sv
module cal_param_bank #(
  parameter int unsigned GAIN_W  = 16,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned FRAC_SH = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gain_we,
  input  logic [GAIN_W-1:0] gain_wdata,
  input  logic              offset_we,
  input  logic [OFF_W-1:0]  offset_wdata,
  output logic [GAIN_W-1:0] gain_q,
  output logic [OFF_W-1:0]  offset_q
);
  localparam logic [GAIN_W-1:0] UNITY_GAIN = GAIN_W'(1) << FRAC_SH;

  // Writes land at the edge; samples accepted at that edge still see the old value.
  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q   <= UNITY_GAIN;
      offset_q <= '0;
    end else begin
      if (gain_we)   gain_q   <= gain_wdata;
      if (offset_we) offset_q <= offset_wdata;
    end
  end
endmodule

// File: rtl/cal_mult_stage.sv
module cal_mult_stage #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned GAIN_W   = 16,
  parameter int unsigned OFF_W    = 16,
  localparam int unsigned PROD_W  = SAMPLE_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [SAMPLE_W-1:0]      in_data,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [OFF_W-1:0]         offset,
  output logic                     prod_valid,
  output logic signed [PROD_W-1:0] prod_q,
  output logic [OFF_W-1:0]         prod_offset
);
  logic signed [SAMPLE_W-1:0] sample_s;
  logic signed [GAIN_W:0]     gain_s;
  logic signed [PROD_W-1:0]   prod_d;

  always_comb begin
    sample_s = $signed(in_data);
    gain_s   = $signed({1'b0, gain});
    prod_d   = sample_s * gain_s;
  end

  // The offset travels with its sample so both parameters belong to one snapshot.
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_valid  <= 1'b0;
      prod_q      <= '0;
      prod_offset <= '0;
    end else begin
      prod_valid <= in_valid;
      if (in_valid) begin
        prod_q      <= prod_d;
        prod_offset <= offset;
      end
    end
  end
endmodule

// File: rtl/cal_round_sat_stage.sv
module cal_round_sat_stage
  import adc_cal_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned GAIN_W   = 16,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned FRAC_SH  = 10,
  localparam int unsigned PROD_W  = SAMPLE_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     prod_valid,
  input  logic signed [PROD_W-1:0] prod_q,
  input  logic [OFF_W-1:0]         prod_offset,
  output logic                     res_valid,
  output logic [SAMPLE_W-1:0]      res_data,
  output logic                     ovf_event
);
  localparam logic signed [PROD_W:0] HALF_LSB =
    {{(PROD_W-FRAC_SH+1){1'b0}}, 1'b1, {(FRAC_SH-1){1'b0}}};
  localparam logic signed [PROD_W:0] WIDE_MAX =
    {{(PROD_W-SAMPLE_W+1){1'b0}}, 1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PROD_W:0] WIDE_MIN =
    {{(PROD_W-SAMPLE_W+1){1'b1}}, 1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] OUT_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] OUT_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [PROD_W:0]   biased;
  logic signed [PROD_W:0]   shifted;
  logic [SAMPLE_W-1:0]      scaled;
  logic                     scale_hi;
  logic                     scale_lo;
  logic signed [SAMPLE_W:0] sum;
  logic                     sum_ovf;
  logic [SAMPLE_W-1:0]      final_val;
  clamp_kind_e              clamp_kind;

  // Round half up, then clamp the scaled value to the sample range.
  always_comb begin
    biased   = {prod_q[PROD_W-1], prod_q} + HALF_LSB;
    shifted  = biased >>> FRAC_SH;
    scale_hi = shifted > WIDE_MAX;
    scale_lo = shifted < WIDE_MIN;
    if (scale_hi)      scaled = OUT_MAX;
    else if (scale_lo) scaled = OUT_MIN;
    else               scaled = shifted[SAMPLE_W-1:0];
  end

  // Offset addition with one guard bit; sign disagreement means overflow.
  always_comb begin
    sum     = $signed({scaled[SAMPLE_W-1], scaled}) +
              $signed({{(SAMPLE_W+1-OFF_W){prod_offset[OFF_W-1]}}, prod_offset});
    sum_ovf = sum[SAMPLE_W] != sum[SAMPLE_W-1];
    if (!sum_ovf)         final_val = sum[SAMPLE_W-1:0];
    else if (sum[SAMPLE_W]) final_val = OUT_MIN;
    else                  final_val = OUT_MAX;
    clamp_kind = clamp_kind_e'({sum_ovf, scale_hi | scale_lo});
  end

  assign ovf_event = prod_valid && (clamp_kind != CLAMP_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= prod_valid;
      if (prod_valid) res_data <= final_val;
    end
  end
endmodule

// File: rtl/cal_ovf_sticky.sv
module cal_ovf_sticky (
  input  logic clk,
  input  logic rst,
  input  logic ovf_event,
  input  logic ovf_clr,
  output logic ovf_flag
);
  // A new event outranks a clear arriving at the same edge.
  always_ff @(posedge clk) begin
    if (rst) ovf_flag <= 1'b0;
    else     ovf_flag <= ovf_event | (ovf_flag & ~ovf_clr);
  end
endmodule

// File: rtl/adc_gain_cal.sv
module adc_gain_cal
  import adc_cal_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_W,
  parameter int unsigned G_W    = GAIN_W,
  parameter int unsigned OFF_W  = SAMPLE_W,
  parameter int unsigned SHIFT  = FRAC_SH,
  localparam int unsigned PROD_W = DATA_W + G_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              gain_we,
  input  logic [G_W-1:0]    gain_wdata,
  input  logic              offset_we,
  input  logic [OFF_W-1:0]  offset_wdata,
  input  logic              ovf_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              ovf_flag
);
  logic [G_W-1:0]           gain_q;
  logic [OFF_W-1:0]         offset_q;
  logic                     prod_valid;
  logic signed [PROD_W-1:0] prod_q;
  logic [OFF_W-1:0]         prod_offset;
  logic                     ovf_event;

  cal_param_bank #(.GAIN_W(G_W), .OFF_W(OFF_W), .FRAC_SH(SHIFT)) u_params (
    .clk(clk), .rst(rst),
    .gain_we(gain_we), .gain_wdata(gain_wdata),
    .offset_we(offset_we), .offset_wdata(offset_wdata),
    .gain_q(gain_q), .offset_q(offset_q)
  );

  cal_mult_stage #(.SAMPLE_W(DATA_W), .GAIN_W(G_W), .OFF_W(OFF_W)) u_mult (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data),
    .gain(gain_q), .offset(offset_q),
    .prod_valid(prod_valid), .prod_q(prod_q), .prod_offset(prod_offset)
  );

  cal_round_sat_stage #(.SAMPLE_W(DATA_W), .GAIN_W(G_W), .OFF_W(OFF_W),
                        .FRAC_SH(SHIFT)) u_round (
    .clk(clk), .rst(rst),
    .prod_valid(prod_valid), .prod_q(prod_q), .prod_offset(prod_offset),
    .res_valid(out_valid), .res_data(out_data), .ovf_event(ovf_event)
  );

  cal_ovf_sticky u_ovf (
    .clk(clk), .rst(rst),
    .ovf_event(ovf_event), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
  );
endmodule

// File: rtl/adc_gain_cal_chk.sv
module adc_gain_cal_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              ovf_clr,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              ovf_flag
);
  // R6
  latency_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> out_valid);
endmodule

bind adc_gain_cal adc_gain_cal_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ovf_clr(ovf_clr),
  .out_valid(out_valid), .out_data(out_data), .ovf_flag(ovf_flag)
);

// File: tb/adc_gain_cal_tb.sv
module adc_gain_cal_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        gain_we = 1'b0;
  logic [15:0] gain_wdata = '0;
  logic        offset_we = 1'b0;
  logic [15:0] offset_wdata = '0;
  logic        ovf_clr = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        ovf_flag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench model state
  logic [15:0] g_m = 16'd1024;
  logic [15:0] o_m = 16'd0;
  bit          flag_m = 0;
  bit          clr_prev = 0;
  logic [15:0] last_d = '0;
  bit p0_v = 0, p1_v = 0;
  bit p0_ov = 0, p1_ov = 0;
  logic [15:0] p0_d = '0, p1_d = '0;
  string p0_tag = "", p1_tag = "";

  always #5 clk = ~clk;

  adc_gain_cal u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .gain_we(gain_we), .gain_wdata(gain_wdata),
    .offset_we(offset_we), .offset_wdata(offset_wdata),
    .ovf_clr(ovf_clr), .out_valid(out_valid), .out_data(out_data),
    .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // Scale by gain/1024 with round half up, clamp, add offset, clamp.
  function automatic void model(input logic [15:0] d, input logic [15:0] g,
                                input logic [15:0] o, output logic [15:0] r,
                                output bit ov);
    longint p = longint'($signed(d)) * longint'(g);
    longint q = (p + 512) >>> 10;
    ov = 0;
    if (q > 32767)  begin q = 32767;  ov = 1; end
    if (q < -32768) begin q = -32768; ov = 1; end
    q = q + longint'($signed(o));
    if (q > 32767)  begin q = 32767;  ov = 1; end
    if (q < -32768) begin q = -32768; ov = 1; end
    r = q[15:0];
  endfunction

  task automatic check_outputs();
    logic [15:0] exp_d;
    flag_m = (p1_v && p1_ov) || (flag_m && !clr_prev);
    chk({"R6 out_valid ", p1_tag}, {15'd0, out_valid}, {15'd0, p1_v});
    exp_d = p1_v ? p1_d : last_d;
    chk(p1_v ? {p1_ov ? "R4 data " : "R2 data ", p1_tag} : "R7 hold", out_data, exp_d);
    if (p1_v) last_d = p1_d;
    chk({"R8 flag ", p1_tag}, {15'd0, ovf_flag}, {15'd0, flag_m});
  endtask

  task automatic step(input bit iv, input logic [15:0] d, input bit gw,
                      input logic [15:0] g, input bit ow, input logic [15:0] o,
                      input bit clr, input string tag);
    logic [15:0] r;
    bit ov;
    @(negedge clk);
    check_outputs();
    in_valid = iv; in_data = d;
    gain_we = gw; gain_wdata = g;
    offset_we = ow; offset_wdata = o;
    ovf_clr = clr;
    model(d, g_m, o_m, r, ov);  // R9: same-edge write not yet visible
    p1_v = p0_v; p1_d = p0_d; p1_ov = p0_ov; p1_tag = p0_tag;
    p0_v = iv; p0_d = r; p0_ov = ov; p0_tag = tag;
    if (gw) g_m = g;
    if (ow) o_m = o;
    clr_prev = clr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0, '0, 0, "idle");
  endtask

  task automatic set_params(input logic [15:0] g, input logic [15:0] o);
    step(0, '0, 1, g, 1, o, 0, "cfg");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] tbl_in [8];
    logic [15:0] tbl_out [8];
    logic [15:0] r;
    bit ov;
    void'($urandom(32'd20240611));
    tbl_in  = '{16'h0000, 16'h0004, 16'h0008, 16'h000B, 16'h0010, 16'h0014, 16'h0018, 16'h001B};
    tbl_out = '{16'h0000, 16'h0004, 16'h0008, 16'h000B, 16'h0011, 16'h0015, 16'h0019, 16'h001C};

    repeat (3) @(negedge clk);
    // R1: outputs cleared in reset
    chk("R1 out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1 out_data", out_data, 16'd0);
    chk("R1 ovf_flag", {15'd0, ovf_flag}, 16'd0);
    rst = 1'b0;
    idle(2);

    // R1: reset gain is unity, offset zero
    step(1, 16'h1234, 0, '0, 0, '0, 0, "R1 default params");
    step(1, 16'h9ABC, 0, '0, 0, '0, 0, "R1 default params");
    idle(2);

    // R2: rounding of the fractional gain into the low bits
    set_params(16'd1063, 16'd0);
    for (int i = 0; i < 8; i++) begin
      model(tbl_in[i], 16'd1063, 16'd0, r, ov);
      chk("R2 table model", r, tbl_out[i]);
      step(1, tbl_in[i], 0, '0, 0, '0, 0, "R2 table");
    end
    idle(2);

    // R3: unity gain is transparent at the range ends
    set_params(16'd1024, 16'd0);
    step(1, 16'h8000, 0, '0, 0, '0, 0, "R3 unity min");
    step(1, 16'h7FFC, 0, '0, 0, '0, 0, "R3 unity max");
    step(1, 16'hFFFC, 0, '0, 0, '0, 0, "R3 unity -4");
    idle(2);

    // R4: scaled value saturates both ways
    set_params(16'd2048, 16'd0);
    step(1, 16'h7FFC, 0, '0, 0, '0, 0, "R4 pos clamp");
    step(1, 16'h8000, 0, '0, 0, '0, 0, "R4 neg clamp");
    idle(2);
    step(0, '0, 0, '0, 0, '0, 1, "R8 clear");
    idle(2);

    // R5: offset sum saturates; scale clamp flags even if offset recovers
    set_params(16'd1024, 16'd100);
    step(1, 16'h7FFC, 0, '0, 0, '0, 1, "R5 sum clamp high");
    set_params(16'd1024, 16'hFF38);
    step(1, 16'h8000, 0, '0, 0, '0, 1, "R5 sum clamp low");
    set_params(16'd2048, 16'hFF9C);
    step(1, 16'h7FFC, 0, '0, 0, '0, 1, "R5 scale clamp then offset");
    idle(2);

    // R8: clear coincides with a new overflow result; flag must stay
    step(1, 16'h7FFC, 0, '0, 0, '0, 1, "R8 sat sample");
    step(0, '0, 0, '0, 0, '0, 1, "R8 clear vs event");
    idle(3);
    step(0, '0, 0, '0, 0, '0, 1, "R8 plain clear");
    idle(2);

    // R9: write at the same edge as a sample uses the old gain and offset
    set_params(16'd1024, 16'd0);
    step(1, 16'h0100, 1, 16'd2048, 1, 16'd7, 0, "R9 same-edge write");
    step(1, 16'h0100, 0, '0, 0, '0, 0, "R9 next sample");
    idle(2);

    // Random streaming with occasional writes and clears
    for (int n = 0; n < 3000; n++) begin
      bit iv, gw, ow, clr;
      logic [15:0] d, g, o;
      iv  = ($urandom % 4) != 0;
      d   = 16'($urandom);
      if (($urandom % 3) == 0) d[1:0] = 2'b00;
      gw  = ($urandom % 10) == 0;
      g   = (($urandom % 5) == 0) ? 16'($urandom) : 16'(900 + $urandom % 300);
      ow  = ($urandom % 12) == 0;
      o   = (($urandom % 4) == 0) ? 16'($urandom) : 16'($signed(8'($urandom)));
      clr = ($urandom % 8) == 0;
      step(iv, d, gw, g, ow, o, clr, "random");
    end
    idle(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule